// File: doc/BRIEF.md
# Peripheral Bus Transfer Sequencer

This block is the only master on a low-speed peripheral bus with fixed two-cycle transfers. A local command port hands it one request at a time: an address, a read/write flag and write data. The block turns each request into a select phase followed by a strobe phase on the bus, and reports completion with a single-cycle pulse that comes with the read data.

The bus has no wait states and no response signals, so every transfer takes exactly two clocks. The target slave is chosen by decoding the top bits of the address into a one-hot select. A new request may be accepted during the strobe phase of the current transfer. That request starts its select phase on the very next clock, so a steady stream of requests keeps the bus busy with no idle cycle between transfers.

Top module: `pbus_sequencer`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, every select is 0, `bus_enable` is 0, `cmd_done` is 0 and `cmd_ready` is 1. Reset is synchronous and active low.
- R2: When `cmd_valid` and `cmd_ready` are both high at a rising edge, the next cycle is the select phase. In that phase `bus_enable` is 0, `bus_addr`, `bus_write` and `bus_wdata` carry the request, and `bus_sel` is one-hot with bit k set, where k is `cmd_addr[ADDR_W-1 -: SLOT_W]`.
- R3: The select phase always lasts exactly one cycle and is followed by the strobe phase. In the strobe phase `bus_enable` is 1, and `bus_sel`, `bus_addr`, `bus_write` and `bus_wdata` hold their select-phase values.
- R4: `cmd_ready` is 1 when the block is idle and during the strobe phase, and 0 during the select phase. A `cmd_valid` raised in the select phase is ignored: the bus address of the transfer in flight does not change.
- R5: In the cycle after the strobe phase, `cmd_done` is 1 for exactly one cycle. For a read, `cmd_rdata` then holds the value `bus_rdata` had at the edge that ended the strobe phase. For a write, `cmd_rdata` is 0.
- R6: A request accepted during the strobe phase enters its select phase on the next cycle, with no idle cycle in between.
- R7: An address whose slot index is NSLV or above asserts no select. The transfer still runs its two cycles and completes, and a read returns 0 whatever `bus_rdata` carries.
- R8: If no request is accepted in the strobe phase, the next cycle is idle: all selects are 0 and `bus_enable` is 0.
- R9: Reset asserted in the middle of a transfer clears all selects and `bus_enable` at the next edge, and it discards the transfer: no `cmd_done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Request present on the command port |
| cmd_addr | input | ADDR_W | Request address; top SLOT_W bits pick the slave |
| cmd_write | input | 1 | 1 for a write, 0 for a read |
| cmd_wdata | input | DATA_W | Write data for the request |
| cmd_ready | output | 1 | The block accepts a request this cycle |
| cmd_done | output | 1 | One-cycle pulse when a transfer completes |
| cmd_rdata | output | DATA_W | Read data of the completed transfer |
| bus_sel | output | NSLV | One-hot slave select |
| bus_enable | output | 1 | Strobe phase indicator |
| bus_addr | output | ADDR_W | Bus address |
| bus_write | output | 1 | Bus write flag |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Read data returned by the selected slave |

## Verification
The assertions check several properties on every cycle: the select is at most one-hot, a select phase is always followed by a strobe phase with the same bus values, a done pulse follows each strobe phase and no other cycle, and the choice after a strobe phase between a new select phase and idle depends on the pending request. They also check that reset clears the bus. Only the bench scenarios can show that the slave index decodes correctly from the address, that the captured read data matches what the slave returned, that write data reaches the bus, and that a request raised during the select phase leaves the transfer in flight untouched.

// File: rtl/pbus_sequencer.sv
module pbus_sequencer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SLOT_W = 3,
  parameter int NSLV   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  output logic              cmd_done,
  output logic [DATA_W-1:0] cmd_rdata,
  output logic [NSLV-1:0]   bus_sel,
  output logic              bus_enable,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);

  localparam int SLOT_LSB = ADDR_W - SLOT_W;

  typedef enum logic [1:0] {IDLE = 2'd0, SETUP = 2'd1, ACCESS = 2'd2} phase_t;

  phase_t            state, state_nx;
  logic [NSLV-1:0]   sel_q, sel_dec;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              wr_q, done_q;
  logic              take;

  wire [SLOT_W-1:0] slot = cmd_addr[ADDR_W-1:SLOT_LSB];

  always_comb begin
    sel_dec = '0;
    for (int i = 0; i < NSLV; i++)
      if (slot == SLOT_W'(i)) sel_dec[i] = 1'b1;
  end

  assign cmd_ready = (state == IDLE) || (state == ACCESS);
  assign take      = cmd_valid && cmd_ready;

  always_comb begin
    case (state)
      IDLE:    state_nx = take ? SETUP : IDLE;
      SETUP:   state_nx = ACCESS;
      ACCESS:  state_nx = take ? SETUP : IDLE;
      default: state_nx = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= IDLE;
      sel_q   <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      state  <= state_nx;
      done_q <= (state == ACCESS);
      if (state == ACCESS)
        rdata_q <= (!wr_q && |sel_q) ? bus_rdata : '0;
      if (take) begin
        sel_q   <= sel_dec;
        addr_q  <= cmd_addr;
        wr_q    <= cmd_write;
        wdata_q <= cmd_wdata;
      end
    end
  end

  assign bus_sel    = (state == IDLE) ? '0 : sel_q;
  assign bus_enable = (state == ACCESS);
  assign bus_addr   = addr_q;
  assign bus_write  = wr_q;
  assign bus_wdata  = wdata_q;
  assign cmd_done   = done_q;
  assign cmd_rdata  = rdata_q;

endmodule

// File: rtl/pbus_sequencer_chk.sv
module pbus_sequencer_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int NSLV   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_done,
  input logic [NSLV-1:0]   bus_sel,
  input logic              bus_enable,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_write,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [1:0]        st
);

  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_sel));

  assert_setup_then_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |=> (bus_enable && $stable(bus_sel) && $stable(bus_addr)
                      && $stable(bus_write) && $stable(bus_wdata)));

  assert_no_take_in_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |-> !cmd_ready);

  assert_done_after_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_enable |=> cmd_done);

  assert_done_only_after_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_enable |=> !cmd_done);

  assert_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_enable && cmd_valid) |=> (st == 2'd1 && !bus_enable));

  assert_return_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_enable && !cmd_valid) |=> (bus_sel == '0 && !bus_enable));

  assert_reset_clears_R9: assert property (@(posedge clk)
    !rst_n |=> (bus_sel == '0 && !bus_enable && !cmd_done));

endmodule

bind pbus_sequencer pbus_sequencer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSLV(NSLV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_done(cmd_done), .bus_sel(bus_sel), .bus_enable(bus_enable),
  .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata),
  .st(state)
);

// File: tb/pbus_sequencer_test.sv
module pbus_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int SLOT_W = 3;
  localparam int NSLV   = 5;
  localparam int NVEC   = 8;

  // {write, addr, wdata, slave read data}
  localparam logic [80:0] VEC [NVEC] = '{
    {1'b1, 16'h0010, 32'hA5A5_0001, 32'h0000_0000},
    {1'b0, 16'h2004, 32'h0000_0000, 32'h1234_5678},
    {1'b1, 16'h8FF0, 32'hDEAD_BEEF, 32'hFFFF_FFFF},
    {1'b0, 16'h4ABC, 32'h0000_0000, 32'hCAFE_F00D},
    {1'b0, 16'hC000, 32'h0000_0000, 32'h5555_AAAA},
    {1'b1, 16'hE00C, 32'h0BAD_0BAD, 32'h0000_0000},
    {1'b0, 16'h6000, 32'h0000_0000, 32'h8000_0001},
    {1'b0, 16'hA002, 32'h0000_0000, 32'h7777_7777}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic              cmd_write = 1'b0;
  logic [DATA_W-1:0] cmd_wdata = '0;
  logic              cmd_ready, cmd_done, bus_enable, bus_write;
  logic [DATA_W-1:0] cmd_rdata, bus_wdata;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic [NSLV-1:0]   bus_sel;
  logic [ADDR_W-1:0] bus_addr;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbus_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W), .NSLV(NSLV)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_write(cmd_write), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
    .cmd_done(cmd_done), .cmd_rdata(cmd_rdata), .bus_sel(bus_sel),
    .bus_enable(bus_enable), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [NSLV-1:0] exp_sel(input logic [ADDR_W-1:0] a);
    int k = int'(a[ADDR_W-1 -: SLOT_W]);
    return (k < NSLV) ? NSLV'(1) << k : '0;
  endfunction

  task automatic drive(input logic w, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
  endtask

  // Starts from idle; leaves the bench at the negedge after completion.
  task automatic xfer(input logic w, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] rd);
    logic [NSLV-1:0] es = exp_sel(a);
    string t = (es == '0) ? "R7" : "R2";
    @(negedge clk);
    chk("R4 ready idle", 64'(cmd_ready), 64'd1);
    drive(w, a, d);
    bus_rdata = rd;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({t, " setup sel"}, 64'(bus_sel), 64'(es));
    chk("R2 setup enable", 64'(bus_enable), 64'd0);
    chk("R2 setup addr", 64'(bus_addr), 64'(a));
    chk("R2 setup write", 64'(bus_write), 64'(w));
    if (w) chk("R2 setup wdata", 64'(bus_wdata), 64'(d));
    chk("R4 ready setup", 64'(cmd_ready), 64'd0);
    @(negedge clk);
    chk("R3 access enable", 64'(bus_enable), 64'd1);
    chk({t == "R7" ? "R7" : "R3", " access sel"}, 64'(bus_sel), 64'(es));
    chk("R3 access addr", 64'(bus_addr), 64'(a));
    chk("R5 no early done", 64'(cmd_done), 64'd0);
    @(negedge clk);
    chk("R5 done", 64'(cmd_done), 64'd1);
    chk({(es == '0) ? "R7" : "R5", " rdata"}, 64'(cmd_rdata),
        64'((w || es == '0) ? '0 : rd));
    chk("R8 idle sel", 64'(bus_sel), 64'd0);
    chk("R8 idle enable", 64'(bus_enable), 64'd0);
    @(negedge clk);
    chk("R5 done one cycle", 64'(cmd_done), 64'd0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sel in reset", 64'(bus_sel), 64'd0);
    chk("R1 enable in reset", 64'(bus_enable), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sel", 64'(bus_sel), 64'd0);
    chk("R1 enable", 64'(bus_enable), 64'd0);
    chk("R1 done", 64'(cmd_done), 64'd0);
    chk("R1 ready", 64'(cmd_ready), 64'd1);

    for (int i = 0; i < NVEC; i++)
      xfer(VEC[i][80], VEC[i][79:64], VEC[i][63:32], VEC[i][31:0]);

    // R6: back-to-back read then write
    @(negedge clk);
    drive(1'b0, 16'h2100, '0);
    bus_rdata = 32'h0102_0304;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    chk("R4 ready access", 64'(cmd_ready), 64'd1);
    drive(1'b1, 16'h8200, 32'h9999_0000);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R6 next setup sel", 64'(bus_sel), 64'(exp_sel(16'h8200)));
    chk("R6 next setup enable", 64'(bus_enable), 64'd0);
    chk("R6 next setup addr", 64'(bus_addr), 64'h8200);
    chk("R6 first done", 64'(cmd_done), 64'd1);
    chk("R6 first rdata", 64'(cmd_rdata), 64'h0102_0304);
    @(negedge clk);
    chk("R6 second access", 64'(bus_enable), 64'd1);
    chk("R6 second wdata", 64'(bus_wdata), 64'h9999_0000);
    @(negedge clk);
    chk("R6 second done", 64'(cmd_done), 64'd1);
    chk("R6 write rdata zero", 64'(cmd_rdata), 64'd0);

    // R4: request during setup is ignored
    @(negedge clk);
    drive(1'b0, 16'h4000, '0);
    bus_rdata = 32'h1111_2222;
    @(negedge clk);
    drive(1'b1, 16'h0F00, 32'h3333_4444);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R4 addr kept", 64'(bus_addr), 64'h4000);
    chk("R4 write kept", 64'(bus_write), 64'd0);
    @(negedge clk);
    chk("R4 read done", 64'(cmd_rdata), 64'h1111_2222);
    chk("R4 no extra transfer", 64'(bus_sel), 64'd0);

    // R9: reset in the setup phase
    @(negedge clk);
    drive(1'b0, 16'h2000, '0);
    @(negedge clk);
    cmd_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 sel cleared", 64'(bus_sel), 64'd0);
    chk("R9 enable cleared", 64'(bus_enable), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 no done", 64'(cmd_done), 64'd0);
    chk("R9 stays idle", 64'(bus_sel), 64'd0);
    chk("R9 ready", 64'(cmd_ready), 64'd1);

    finish_run();
  end
endmodule